// File: doc/BRIEF.md
# Interrupt Controller Protected Register File

This block is the register file of a vectored interrupt controller. It holds a software interrupt register, an enable mask, an access-protection bit and a vector address register. A simple single-cycle bus slave reaches these registers. Each transfer carries a word offset, a write flag, write data and a flag that marks it as privileged. Software-raised interrupts are OR-ed with the hardware interrupt lines before the enable mask is applied. The masked result drives the interrupt status output.

When protection is switched on, the block accepts only privileged transfers. The protection bit can be read or changed only by a privileged transfer, whatever its current value. A refused transfer changes nothing. It returns zero read data and raises the error output for one cycle. Read data and the error flag are registered and appear in the cycle after the request.

Top module: `vic_regfile`

## Requirements
- R1: After reset the software, enable, protection and vector registers are all zero, `err_o` is 0, `rdata_o` is 0 and `irq_o` is 0.
- R2: `irq_o` equals (`hw_irq_i` OR software register) AND enable register. A software bit raises its line even when the hardware line is low.
- R3: Offset 3 reads back the software register. A write there sets each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: Offset 4 is a write-only clear port. Writing 1 in a bit clears that software bit, and writing 0 leaves it unchanged. Reading offset 4 returns 0.
- R5: Offset 5 is the protection register, with the control in bit 0. Writes to bits 31:1 are ignored, and a read returns 0 in bits 31:1.
- R6: While the protection bit is 1, a non-privileged access to any offset is refused, and privileged accesses are accepted. While the bit is 0, both kinds are accepted at every offset except 5.
- R7: A non-privileged access to offset 5 is always refused, whatever the value of the protection bit.
- R8: A refused access changes no register. In the next cycle it returns `rdata_o` = 0 and `err_o` = 1 for exactly that cycle.
- R9: Offset 6 is the 32-bit vector address register. It is readable and writable.
- R10: Offset 2 is the enable register and is readable and writable. Offset 0 reads the masked status and offset 1 reads the unmasked status (hardware OR software). Writes to offsets 0, 1 and 7 are accepted but change nothing, and offset 7 reads 0.
- R11: Read data appears on `rdata_o` in the cycle after the request, and reads 0 in any cycle without an accepted read. A register write shows on `irq_o` in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_irq_i | input | NUM_IRQ | Raw hardware interrupt lines |
| req_i | input | 1 | Bus transfer request |
| we_i | input | 1 | 1 = write, 0 = read |
| priv_i | input | 1 | Transfer is privileged |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| err_o | output | 1 | One-cycle pulse for a refused access |
| irq_o | output | NUM_IRQ | Masked interrupt status |

## Verification
A wrong software or enable bit shows on `irq_o` in the cycle right after the write that caused it. Every random step compares that bus against the model. A protection bit that is wrongly held or lost shows on the next transfer of the wrong privilege, as an `err_o` pulse or a zero read that the model did not predict. A write that lands when it should have been refused is caught at the next read of that register. Random traffic reads every offset often, so such an error shows within a few transfers.

// File: rtl/vic_reg_pkg.sv
package vic_reg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFF_STAT = 3'd0,
    OFF_RAW  = 3'd1,
    OFF_EN   = 3'd2,
    OFF_SSET = 3'd3,
    OFF_SCLR = 3'd4,
    OFF_PROT = 3'd5,
    OFF_VEC  = 3'd6,
    OFF_NONE = 3'd7
  } reg_off_e;
endpackage

// File: rtl/vic_access_guard.sv
module vic_access_guard
  import vic_reg_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic              prot_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_ok_o,
  output logic              rd_ok_o,
  output logic              reject_o
);
  logic is_prot, allow;

  always_comb begin
    is_prot  = (addr_i == OFF_PROT);
    // protection register always needs privilege; others only when protected
    allow    = priv_i | (~prot_i & ~is_prot);
    wr_ok_o  = req_i & we_i & allow;
    rd_ok_o  = req_i & ~we_i & allow;
    reject_o = req_i & ~allow;
  end
endmodule

// File: rtl/vic_soft_bank.sv
module vic_soft_bank #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] soft_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      soft_o[i] <= 1'b0;
      else if (clr_en_i && mask_i[i])   soft_o[i] <= 1'b0;  // clear wins
      else if (set_en_i && mask_i[i])   soft_o[i] <= 1'b1;
    end
  end

  p_clear_hits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((soft_o & $past(mask_i)) == '0));

  p_zero_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i && !clr_en_i) |=>
      ((soft_o & ~$past(mask_i)) == ($past(soft_o) & ~$past(mask_i))));
endmodule

// File: rtl/vic_irq_merge.sv
module vic_irq_merge #(
  parameter int N = 32
) (
  input  logic [N-1:0] hw_i,
  input  logic [N-1:0] soft_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign raw_o[i] = hw_i[i] | soft_i[i];
    assign irq_o[i] = raw_o[i] & en_i[i];
  end
endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
  import vic_reg_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] hw_irq_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic               priv_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  localparam int PAD_W = DATA_W - NUM_IRQ;

  logic               wr_ok, rd_ok, reject;
  logic               prot_q;
  logic [NUM_IRQ-1:0] en_q, soft_q, raw;
  logic [DATA_W-1:0]  vec_q, rd_mux;
  logic               set_en, clr_en;

  vic_access_guard u_guard (
    .req_i    (req_i),
    .we_i     (we_i),
    .priv_i   (priv_i),
    .prot_i   (prot_q),
    .addr_i   (addr_i),
    .wr_ok_o  (wr_ok),
    .rd_ok_o  (rd_ok),
    .reject_o (reject)
  );

  assign set_en = wr_ok && (addr_i == OFF_SSET);
  assign clr_en = wr_ok && (addr_i == OFF_SCLR);

  vic_soft_bank #(.N(NUM_IRQ)) u_soft (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (set_en),
    .clr_en_i (clr_en),
    .mask_i   (wdata_i[NUM_IRQ-1:0]),
    .soft_o   (soft_q)
  );

  vic_irq_merge #(.N(NUM_IRQ)) u_merge (
    .hw_i   (hw_irq_i),
    .soft_i (soft_q),
    .en_i   (en_q),
    .raw_o  (raw),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      prot_q <= 1'b0;
      vec_q  <= '0;
    end else if (wr_ok) begin
      case (addr_i)
        OFF_EN:   en_q   <= wdata_i[NUM_IRQ-1:0];
        OFF_PROT: prot_q <= wdata_i[0];
        OFF_VEC:  vec_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      OFF_STAT: rd_mux = {{PAD_W{1'b0}}, irq_o};
      OFF_RAW:  rd_mux = {{PAD_W{1'b0}}, raw};
      OFF_EN:   rd_mux = {{PAD_W{1'b0}}, en_q};
      OFF_SSET: rd_mux = {{PAD_W{1'b0}}, soft_q};
      OFF_PROT: rd_mux = {{(DATA_W-1){1'b0}}, prot_q};
      OFF_VEC:  rd_mux = vec_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rd_ok ? rd_mux : '0;
      err_o   <= reject;
    end
  end

  p_user_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !priv_i && prot_q) |=>
      ($stable(en_q) && $stable(vec_q) && $stable(soft_q) && err_o));

  p_prot_priv_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !priv_i && addr_i == OFF_PROT) |=> ($stable(prot_q) && err_o));

  p_reject_no_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));

  p_clr_reads_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFF_SCLR) |=> (rdata_o == '0));

  p_idle_no_data_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (rdata_o == '0 && !err_o));
endmodule

// File: tb/vic_regfile_test.sv
module vic_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  hw_irq = '0;
  logic          req = 1'b0, we = 1'b0, priv = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          err;
  logic [N-1:0]  irq;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model
  logic [N-1:0] m_soft = '0, m_en = '0;
  logic         m_prot = 1'b0;
  logic [31:0]  m_vec = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_regfile uut (
    .clk_i(clk), .rst_ni(rst_ni), .hw_irq_i(hw_irq), .req_i(req), .we_i(we),
    .priv_i(priv), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .err_o(err), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a, input logic [N-1:0] hw);
    case (a)
      3'd0: return (hw | m_soft) & m_en;
      3'd1: return hw | m_soft;
      3'd2: return m_en;
      3'd3: return m_soft;
      3'd5: return {31'd0, m_prot};
      3'd6: return m_vec;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit m_allow(input logic [2:0] a, input bit p);
    return p || (!m_prot && a != 3'd5);
  endfunction

  task automatic op(input bit w, input logic [2:0] a, input logic [31:0] d,
                    input bit p, input logic [N-1:0] hw, input string tag);
    logic [31:0] exp_rd;
    bit          ok;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; priv = p; hw_irq = hw;
    ok     = m_allow(a, p);
    exp_rd = (!w && ok) ? m_read(a, hw) : 32'd0;
    if (w && ok) begin
      case (a)
        3'd2: m_en = d;
        3'd3: m_soft = m_soft | d;
        3'd4: m_soft = m_soft & ~d;
        3'd5: m_prot = d[0];
        3'd6: m_vec = d;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    req = 1'b0;
    chk(rdata == exp_rd, {tag, " rdata"}, rdata, exp_rd);
    chk(err == !ok, {tag, " err"}, {31'd0, err}, {31'd0, !ok});
    chk(irq == ((hw | m_soft) & m_en), {tag, " irq"}, irq, (hw | m_soft) & m_en);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdata == 0 && err == 0, "R1 outputs", {rdata[30:0], err}, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    op(0, 3'd2, 0, 0, '0, "R1 enable");
    op(0, 3'd3, 0, 0, '0, "R1 soft");
    op(0, 3'd5, 0, 1, '0, "R1 prot");
    op(0, 3'd6, 0, 0, '0, "R1 vector");
    // R10 enable, R2 soft ahead of mask
    op(1, 3'd2, 32'h0000_ffff, 0, '0, "R10 enable write");
    op(1, 3'd3, 32'h0001_0003, 0, '0, "R3 soft set");
    op(0, 3'd3, 0, 0, '0, "R3 soft read");
    op(0, 3'd1, 0, 0, 32'h0100_0000, "R10 raw read");
    op(0, 3'd0, 0, 0, 32'h0000_0100, "R2 masked read");
    op(1, 3'd3, 32'h0, 0, '0, "R3 zero no effect");
    // R4 clear port
    op(1, 3'd4, 32'h0000_0001, 0, '0, "R4 clear bit0");
    op(1, 3'd4, 32'h0, 0, '0, "R4 clear zero no effect");
    op(0, 3'd4, 0, 0, '0, "R4 read zero");
    op(1, 3'd0, 32'hffff_ffff, 0, '0, "R10 stat write ignored");
    op(1, 3'd7, 32'hffff_ffff, 0, '0, "R10 spare offset");
    // R9 vector
    op(1, 3'd6, 32'hdead_beef, 0, '0, "R9 vector write");
    op(0, 3'd6, 0, 0, '0, "R9 vector read");
    // R7 user cannot touch protection
    op(1, 3'd5, 32'h1, 0, '0, "R7 user prot write");
    op(0, 3'd5, 0, 0, '0, "R7 user prot read");
    // R5 reserved bits
    op(1, 3'd5, 32'hffff_ffff, 1, '0, "R5 prot set");
    op(0, 3'd5, 0, 1, '0, "R5 prot read");
    // R6 / R8 locked user access
    op(1, 3'd2, 32'h0, 0, 32'h1, "R8 user write refused");
    op(0, 3'd2, 0, 0, '0, "R6 user read refused");
    op(0, 3'd2, 0, 1, '0, "R6 priv read ok");
    op(1, 3'd6, 32'h1234_5678, 1, '0, "R6 priv write ok");
    @(negedge clk);
    chk(err == 0 && rdata == 0, "R8 R11 idle after", {rdata[30:0], err}, 0);
    op(1, 3'd5, 32'h0, 1, '0, "R6 prot clear");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      logic [2:0]  a;
      d = $urandom;
      a = 3'($urandom % 8);
      if (a == 3'd5) d = {d[31:1], ($urandom % 4) == 0};
      op(1'($urandom % 2), a, d, ($urandom % 4) != 0, N'($urandom), "R2 R6 R8 random");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule